// File: doc/BRIEF.md
# Trigger Coincidence Delay Matcher

This block lines up per-channel trigger primitives with the level-1 accept (L1A) that arrives much later for the same bunch crossing. Each of seven primitive inputs runs through its own delay pipeline whose depth is a fixed base of 100 crossings plus a 6-bit programmable amount. When the delayed primitive and an incoming L1A are both high in the same clock cycle, the channel issues a one-cycle match pulse. Two auxiliary data-available flags, which arrive after the L1A, are paired with a copy of the L1A history that is delayed by a separate 6-bit amount for each flag.

For timing tuning, the block latches the crossing distance from the latest primitive to each L1A on every channel, and the distance from the latest L1A to each data-available flag. A pedestal mode forces a match on every channel for each L1A. A kill mask can block the forwarded L1A and any channel's match. Counters record L1As (one copy cleared by resync, one only by reset), primitives per channel and issued matches per channel.

Top module: `trig_coinc_matcher`

## Requirements
- R1: While `rst` is high at a clock edge, every output becomes zero at that edge: strobes, match bits, latched gaps and all counters.
- R2: `match_out[c]` is high for exactly the cycle after a cycle in which `l1a_in` is high and `lct_in[c]` was high exactly 100 + `lct_dly` cycles earlier (`lct_dly` from 0 to 63); `match_out` bit 0 belongs to channel 1.
- R3: A primitive that is 99 + `lct_dly` or 101 + `lct_dly` cycles older than the L1A gives no match on that channel.
- R4: With `ped_mode` high, each L1A gives a match on every channel that is not killed, whether or not primitives were seen.
- R5: `l1a_out` repeats `l1a_in` one cycle later unless `kill_mask[0]` is high; `kill_mask[c+1]` suppresses `match_out[c]`.
- R6: `dav_a_match` is high the cycle after `dav_a_in` is high while `l1a_in` was high `dav_a_dly` cycles earlier (0 means the same cycle); `dav_b_match` behaves likewise using `dav_b_dly`.
- R7: On each L1A, channel c latches into its 8-bit field of `gap_lct_o` (bits 8c+7..8c) the number of cycles since its latest primitive: 0 if one arrives in the same cycle, saturating at 255, and 255 if none has arrived since reset. The value appears the next cycle and holds until the next L1A.
- R8: On each `dav_a_in` (resp. `dav_b_in`), `gap_dav_a_o` (resp. `gap_dav_b_o`) latches the cycles since the latest L1A with the same rules as R7.
- R9: `l1a_cnt_run` and `l1a_cnt_total` count cycles with `l1a_in` high, independent of the kill mask, wrapping at 16 bits; `resync` clears only `l1a_cnt_run`, and resync wins over a coincident L1A.
- R10: Per channel, `lct_cnt_o` (16 bits per channel, channel c at bits 16c+15..16c) counts cycles with `lct_in[c]` high, and `match_cnt_o` in the same layout counts issued `match_out[c]` pulses, both wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous active-high hard reset |
| resync | input | 1 | Clears the run L1A counter |
| lct_in | input | 7 | Trigger primitive per channel |
| l1a_in | input | 1 | Level-1 accept |
| dav_a_in | input | 1 | First data-available flag |
| dav_b_in | input | 1 | Second data-available flag |
| lct_dly | input | 6 | Programmable part of the primitive delay |
| dav_a_dly | input | 6 | L1A delay used for the first flag |
| dav_b_dly | input | 6 | L1A delay used for the second flag |
| ped_mode | input | 1 | Force matches on every L1A |
| kill_mask | input | 8 | Bit 0 blocks l1a_out, bits 1..7 block channel matches |
| l1a_out | output | 1 | Forwarded L1A |
| match_out | output | 7 | Per-channel match pulse |
| dav_a_match | output | 1 | First flag coincided with delayed L1A |
| dav_b_match | output | 1 | Second flag coincided with delayed L1A |
| gap_lct_o | output | 56 | Latched primitive-to-L1A gap per channel |
| gap_dav_a_o | output | 8 | Latched L1A-to-first-flag gap |
| gap_dav_b_o | output | 8 | Latched L1A-to-second-flag gap |
| l1a_cnt_run | output | 16 | L1A count cleared by resync |
| l1a_cnt_total | output | 16 | L1A count cleared only by reset |
| lct_cnt_o | output | 112 | Primitive count per channel |
| match_cnt_o | output | 112 | Match count per channel |

## Verification
The bound assertions watch, on every cycle, that no match or flag pulse appears without the L1A or flag one cycle before, that killed outputs stay low, that pedestal mode lights every unkilled channel, that resync empties the run counter and that the total counter moves only after an L1A. Whether a match lands at exactly the programmed depth and not one crossing either side, the latched gap values with their saturation, and the counter contents can only be shown by the bench's reference model, which keeps the full input history and compares every output each cycle through directed off-by-one cases, delay extremes and random traffic with changing delays.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    localparam int NUM_CH    = 7;
    localparam int DLY_BITS  = 6;
    localparam int PIPE_BASE = 100;
    localparam int GAP_BITS  = 8;
    localparam int CNT_BITS  = 16;

    // registered single-cycle strobes leaving the block
    typedef struct packed {
        logic l1a;
        logic dav_a;
        logic dav_b;
    } strobe_t;

    // width of an index that addresses depth entries
    function automatic int idx_bits(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/tcm_delay_line.sv
module tcm_delay_line
    import tcm_pkg::*;
#(
    parameter int BASE  = 100,
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             tap
);
    localparam int DEPTH = BASE + (1 << SEL_W) - 1;
    localparam int IW    = idx_bits(DEPTH);

    // hist[k] holds din from k+1 cycles ago
    logic [DEPTH-1:0] hist;
    logic [IW-1:0]    idx;

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[DEPTH-2:0], din};
    end

    generate
        if (BASE == 0) begin : g_zero_base
            always_comb begin
                idx = IW'(sel) - IW'(1);
                tap = (sel == '0) ? din : hist[idx];
            end
        end else begin : g_offset_base
            always_comb begin
                idx = IW'(BASE - 1) + IW'(sel);
                tap = hist[idx];
            end
        end
    endgenerate

endmodule

// File: rtl/tcm_gap_meter.sv
module tcm_gap_meter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_ev,
    input  logic         stop_ev,
    output logic [W-1:0] gap_o
);
    localparam logic [W-1:0] TOP = '1;

    // cycles since the last start event, saturating; TOP when none seen
    logic [W-1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age   <= TOP;
            gap_o <= '0;
        end else begin
            if (start_ev)        age <= W'(1);
            else if (age != TOP) age <= age + W'(1);
            if (stop_ev)         gap_o <= start_ev ? '0 : age;
        end
    end

endmodule

// File: rtl/tcm_counter.sv
module tcm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt_o <= '0;
        else if (inc)   cnt_o <= cnt_o + W'(1);
    end
endmodule

// File: rtl/trig_coinc_matcher.sv
module trig_coinc_matcher
    import tcm_pkg::*;
#(
    parameter int NCH   = NUM_CH,
    parameter int DLY_W = DLY_BITS,
    parameter int BASE  = PIPE_BASE,
    parameter int GAP_W = GAP_BITS,
    parameter int CNT_W = CNT_BITS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   resync,
    input  logic [NCH-1:0]         lct_in,
    input  logic                   l1a_in,
    input  logic                   dav_a_in,
    input  logic                   dav_b_in,
    input  logic [DLY_W-1:0]       lct_dly,
    input  logic [DLY_W-1:0]       dav_a_dly,
    input  logic [DLY_W-1:0]       dav_b_dly,
    input  logic                   ped_mode,
    input  logic [NCH:0]           kill_mask,
    output logic                   l1a_out,
    output logic [NCH-1:0]         match_out,
    output logic                   dav_a_match,
    output logic                   dav_b_match,
    output logic [NCH*GAP_W-1:0]   gap_lct_o,
    output logic [GAP_W-1:0]       gap_dav_a_o,
    output logic [GAP_W-1:0]       gap_dav_b_o,
    output logic [CNT_W-1:0]       l1a_cnt_run,
    output logic [CNT_W-1:0]       l1a_cnt_total,
    output logic [NCH*CNT_W-1:0]   lct_cnt_o,
    output logic [NCH*CNT_W-1:0]   match_cnt_o
);
    logic [NCH-1:0] lct_late;
    logic [NCH-1:0] hit;
    logic           l1a_for_a, l1a_for_b;
    strobe_t        strobe_d, strobe_q;

    // per-channel pipeline, coincidence, gap and counters
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tcm_delay_line #(.BASE(BASE), .SEL_W(DLY_W)) u_pipe (
            .clk (clk), .rst (rst), .din (lct_in[c]),
            .sel (lct_dly), .tap (lct_late[c])
        );

        assign hit[c] = l1a_in && (ped_mode || lct_late[c]) && !kill_mask[c+1];

        tcm_gap_meter #(.W(GAP_W)) u_gap (
            .clk (clk), .rst (rst), .start_ev (lct_in[c]), .stop_ev (l1a_in),
            .gap_o (gap_lct_o[c*GAP_W +: GAP_W])
        );

        tcm_counter #(.W(CNT_W)) u_lct_cnt (
            .clk (clk), .rst (rst), .clr (1'b0), .inc (lct_in[c]),
            .cnt_o (lct_cnt_o[c*CNT_W +: CNT_W])
        );

        tcm_counter #(.W(CNT_W)) u_match_cnt (
            .clk (clk), .rst (rst), .clr (1'b0), .inc (hit[c]),
            .cnt_o (match_cnt_o[c*CNT_W +: CNT_W])
        );
    end

    // L1A histories for the two data-available flags
    tcm_delay_line #(.BASE(0), .SEL_W(DLY_W)) u_l1a_hist_a (
        .clk (clk), .rst (rst), .din (l1a_in), .sel (dav_a_dly), .tap (l1a_for_a)
    );
    tcm_delay_line #(.BASE(0), .SEL_W(DLY_W)) u_l1a_hist_b (
        .clk (clk), .rst (rst), .din (l1a_in), .sel (dav_b_dly), .tap (l1a_for_b)
    );

    tcm_gap_meter #(.W(GAP_W)) u_gap_a (
        .clk (clk), .rst (rst), .start_ev (l1a_in), .stop_ev (dav_a_in), .gap_o (gap_dav_a_o)
    );
    tcm_gap_meter #(.W(GAP_W)) u_gap_b (
        .clk (clk), .rst (rst), .start_ev (l1a_in), .stop_ev (dav_b_in), .gap_o (gap_dav_b_o)
    );

    tcm_counter #(.W(CNT_W)) u_l1a_run (
        .clk (clk), .rst (rst), .clr (resync), .inc (l1a_in), .cnt_o (l1a_cnt_run)
    );
    tcm_counter #(.W(CNT_W)) u_l1a_total (
        .clk (clk), .rst (rst), .clr (1'b0), .inc (l1a_in), .cnt_o (l1a_cnt_total)
    );

    always_comb begin
        strobe_d.l1a   = l1a_in && !kill_mask[0];
        strobe_d.dav_a = dav_a_in && l1a_for_a;
        strobe_d.dav_b = dav_b_in && l1a_for_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q  <= '0;
            match_out <= '0;
        end else begin
            strobe_q  <= strobe_d;
            match_out <= hit;
        end
    end

    assign l1a_out     = strobe_q.l1a;
    assign dav_a_match = strobe_q.dav_a;
    assign dav_b_match = strobe_q.dav_b;

endmodule

// File: rtl/tcm_checker.sv
module tcm_checker #(
    parameter int NCH   = 7,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             resync,
    input logic             l1a_in,
    input logic             dav_a_in,
    input logic             dav_b_in,
    input logic             ped_mode,
    input logic [NCH:0]     kill_mask,
    input logic             l1a_out,
    input logic [NCH-1:0]   match_out,
    input logic             dav_a_match,
    input logic             dav_b_match,
    input logic [CNT_W-1:0] l1a_cnt_run,
    input logic [CNT_W-1:0] l1a_cnt_total
);
    // R2
    match_needs_l1a_chk: assert property (@(posedge clk) disable iff (rst)
        (match_out != '0) |-> $past(l1a_in));

    // R4
    ped_all_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ped_mode && l1a_in) |-> (match_out == ~$past(kill_mask[NCH:1])));

    // R5
    kill_l1a_chk: assert property (@(posedge clk) disable iff (rst)
        $past(kill_mask[0]) |-> !l1a_out);

    // R5
    kill_match_chk: assert property (@(posedge clk) disable iff (rst)
        (match_out & $past(kill_mask[NCH:1])) == '0);

    // R6
    dav_a_src_chk: assert property (@(posedge clk) disable iff (rst)
        dav_a_match |-> $past(dav_a_in));

    // R6
    dav_b_src_chk: assert property (@(posedge clk) disable iff (rst)
        dav_b_match |-> $past(dav_b_in));

    // R9
    resync_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $past(resync) |-> (l1a_cnt_run == '0));

    // R9
    total_step_chk: assert property (@(posedge clk) disable iff (rst)
        (l1a_cnt_total != $past(l1a_cnt_total)) |-> $past(l1a_in));
endmodule

bind trig_coinc_matcher tcm_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk (clk), .rst (rst), .resync (resync), .l1a_in (l1a_in),
    .dav_a_in (dav_a_in), .dav_b_in (dav_b_in), .ped_mode (ped_mode),
    .kill_mask (kill_mask), .l1a_out (l1a_out), .match_out (match_out),
    .dav_a_match (dav_a_match), .dav_b_match (dav_b_match),
    .l1a_cnt_run (l1a_cnt_run), .l1a_cnt_total (l1a_cnt_total)
);

// File: tb/sim_trig_coinc_matcher.sv
`timescale 1ns/1ps
module sim_trig_coinc_matcher;
    localparam int NCH = 7, DW = 6, BASE = 100, GW = 8, CW = 16;
    localparam int GMAX = (1 << GW) - 1;
    localparam int CMASK = (1 << CW) - 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, resync, l1a_in, dav_a_in, dav_b_in, ped_mode;
    logic [NCH-1:0] lct_in;
    logic [DW-1:0] lct_dly, dav_a_dly, dav_b_dly;
    logic [NCH:0] kill_mask;
    logic l1a_out, dav_a_match, dav_b_match;
    logic [NCH-1:0] match_out;
    logic [NCH*GW-1:0] gap_lct_o;
    logic [GW-1:0] gap_dav_a_o, gap_dav_b_o;
    logic [CW-1:0] l1a_cnt_run, l1a_cnt_total;
    logic [NCH*CW-1:0] lct_cnt_o, match_cnt_o;

    trig_coinc_matcher u0 (.*);

    int n_chk = 0, n_bad = 0;

    // reference model state
    logic [NCH-1:0] lq[$];
    bit aq[$];
    int last_lct[NCH];
    int last_l1a;
    logic e_l1a, e_da, e_db;
    logic [NCH-1:0] e_match;
    int e_gap[NCH];
    int e_gapa, e_gapb, e_run, e_tot;
    int e_lc[NCH];
    int e_mc[NCH];

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int gapv(input int last, input int now);
        if (last < 0) return GMAX;
        return (now - last > GMAX) ? GMAX : now - last;
    endfunction

    function automatic logic [NCH-1:0] lct_ago(input int k);
        int n = lq.size();
        return (k >= 1 && k <= n) ? lq[n-k] : '0;
    endfunction

    function automatic bit l1a_ago(input int k, input bit cur);
        int n = aq.size();
        if (k == 0) return cur;
        return (k <= n) ? aq[n-k] : 1'b0;
    endfunction

    task automatic compare_all();
        check("R5 l1a_out", l1a_out, e_l1a);
        check("R2 match_out", match_out, e_match);
        check("R6 dav_a_match", dav_a_match, e_da);
        check("R6 dav_b_match", dav_b_match, e_db);
        for (int c = 0; c < NCH; c++) begin
            check("R7 gap_lct", gap_lct_o[c*GW +: GW], e_gap[c]);
            check("R10 lct_cnt", lct_cnt_o[c*CW +: CW], e_lc[c]);
            check("R10 match_cnt", match_cnt_o[c*CW +: CW], e_mc[c]);
        end
        check("R8 gap_dav_a", gap_dav_a_o, e_gapa);
        check("R8 gap_dav_b", gap_dav_b_o, e_gapb);
        check("R9 l1a_cnt_run", l1a_cnt_run, e_run);
        check("R9 l1a_cnt_total", l1a_cnt_total, e_tot);
    endtask

    task automatic cycle(input logic r, input logic rs, input logic [NCH-1:0] lct,
                         input bit l1a, input bit da, input bit db);
        int t;
        rst = r; resync = rs; lct_in = lct; l1a_in = l1a; dav_a_in = da; dav_b_in = db;
        if (r) begin
            lq.delete(); aq.delete();
            last_l1a = -1; e_l1a = 0; e_da = 0; e_db = 0; e_match = '0;
            e_gapa = 0; e_gapb = 0; e_run = 0; e_tot = 0;
            for (int c = 0; c < NCH; c++) begin
                last_lct[c] = -1; e_gap[c] = 0; e_lc[c] = 0; e_mc[c] = 0;
            end
        end else begin
            t = lq.size();
            e_l1a = l1a && !kill_mask[0];
            for (int c = 0; c < NCH; c++) begin
                e_match[c] = l1a && (ped_mode || lct_ago(BASE + int'(lct_dly))[c]) && !kill_mask[c+1];
                if (l1a) e_gap[c] = lct[c] ? 0 : gapv(last_lct[c], t);
                e_lc[c] = (e_lc[c] + int'(lct[c])) & CMASK;
                e_mc[c] = (e_mc[c] + int'(e_match[c])) & CMASK;
                if (lct[c]) last_lct[c] = t;
            end
            e_da = da && l1a_ago(int'(dav_a_dly), l1a);
            e_db = db && l1a_ago(int'(dav_b_dly), l1a);
            if (da) e_gapa = l1a ? 0 : gapv(last_l1a, t);
            if (db) e_gapb = l1a ? 0 : gapv(last_l1a, t);
            e_run = rs ? 0 : (e_run + int'(l1a)) & CMASK;
            e_tot = (e_tot + int'(l1a)) & CMASK;
            if (l1a) last_l1a = t;
            lq.push_back(lct);
            aq.push_back(l1a);
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, '0, 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        lct_dly = 6'd5; dav_a_dly = 6'd0; dav_b_dly = 6'd63;
        ped_mode = 0; kill_mask = '0;
        cycle(1, 0, '0, 0, 0, 0);
        cycle(1, 1, '1, 1, 1, 1);
        cycle(1, 0, '0, 0, 0, 0);
        // R1: all outputs cleared by reset
        check("R1 reset strobes", {l1a_out, match_out, dav_a_match, dav_b_match}, '0);
        check("R1 reset counters", {l1a_cnt_run, l1a_cnt_total, lct_cnt_o, match_cnt_o}, '0);
        check("R1 reset gaps", {gap_lct_o, gap_dav_a_o, gap_dav_b_o}, '0);

        // R2: primitive on channel index 2, L1A exactly 105 cycles later
        cycle(0, 0, 7'b0000100, 0, 0, 0);
        idle(104);
        cycle(0, 0, '0, 1, 0, 0);
        check("R2 exact depth match", match_out, 7'b0000100);
        idle(1);
        check("R2 single-cycle pulse", match_out, '0);
        // R7: latched gap and saturation for untouched channel
        check("R7 gap ch2", gap_lct_o[2*GW +: GW], 8'd106 - 8'd1);
        check("R7 gap none seen", gap_lct_o[6*GW +: GW], 8'd255);

        // R3: one cycle early and one cycle late
        cycle(0, 0, 7'b0000001, 0, 0, 0);
        idle(103);
        cycle(0, 0, '0, 1, 0, 0);
        check("R3 early no match", match_out[0], 1'b0);
        idle(1);
        cycle(0, 0, '0, 1, 0, 0);
        check("R3 late no match", match_out[0], 1'b0);

        // R2 at the delay extremes
        lct_dly = 6'd0;
        cycle(0, 0, 7'b1000000, 0, 0, 0);
        idle(99);
        cycle(0, 0, '0, 1, 0, 0);
        check("R2 min delay", match_out, 7'b1000000);
        lct_dly = 6'd63;
        cycle(0, 0, 7'b0010000, 0, 0, 0);
        idle(162);
        cycle(0, 0, '0, 1, 0, 0);
        check("R2 max delay", match_out, 7'b0010000);

        // R4: pedestal forces all matches
        ped_mode = 1;
        cycle(0, 0, '0, 1, 0, 0);
        check("R4 pedestal all", match_out, 7'h7f);
        // R5: kill mask
        kill_mask = 8'b0000_0101;
        cycle(0, 0, '0, 1, 0, 0);
        check("R5 kill l1a", l1a_out, 1'b0);
        check("R5 kill match", match_out, 7'h7d);
        ped_mode = 0; kill_mask = '0;

        // R6: flag delays 0 and 63
        idle(3);
        cycle(0, 0, '0, 1, 1, 0);
        check("R6 dav_a same cycle", dav_a_match, 1'b1);
        check("R8 gap_dav_a zero", gap_dav_a_o, 8'd0);
        idle(62);
        cycle(0, 0, '0, 0, 0, 1);
        check("R6 dav_b at 63", dav_b_match, 1'b1);
        check("R8 gap_dav_b 63", gap_dav_b_o, 8'd63);

        // R9: resync against coincident L1A
        cycle(0, 1, '0, 1, 0, 0);
        check("R9 resync wins", l1a_cnt_run, 16'd0);
        check("R9 total kept", l1a_cnt_total == 16'd0, 1'b0);

        // random traffic with changing configuration
        for (int seg = 0; seg < 6; seg++) begin
            lct_dly = DW'($urandom_range(0, 63));
            dav_a_dly = DW'($urandom_range(0, 63));
            dav_b_dly = DW'($urandom_range(0, 63));
            ped_mode = (seg == 3);
            kill_mask = (seg == 4) ? (NCH+1)'($urandom) : '0;
            for (int i = 0; i < 500; i++)
                cycle(0, ($urandom_range(0, 199) == 0),
                      NCH'($urandom & $urandom & $urandom),
                      ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
                      ($urandom_range(0, 5) == 0));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule